// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small, fully associative translation buffer that sits between a processor's load/store stage and its operand memory. Each lookup presents a virtual address and says whether the access is a read or a write. The upper part of the address, the virtual page number, is compared directly against the page tags held in the entries. On a hit the matching entry's frame number replaces the page number, the in-page offset passes through unchanged, and the entry's cacheable flag comes back with the translated address. The answer is registered and appears one clock after the request.

There is no hardware table walker. A lookup that matches no entry raises a trap request, in the same way as a lookup that hits an entry whose rights mark it unusable, or a write that hits a page marked read-only. A two-bit cause code tells the trap handler which case occurred. The handler then loads an entry through a write port that names the slot, the page, the frame and the three rights flags. Loading a page into one slot drops any other slot holding the same page, so a lookup never matches twice. A flush input empties the whole buffer in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup request in one cycle gives `rsp_valid` high in the next cycle, and on a successful translation `rsp_paddr` is the entry's frame number above the unchanged low 12 bits of `lk_vaddr`.
- R2: A lookup that matches a live entry with its usable flag set, and that is a read or targets a writable entry, gives `rsp_trap` low, `rsp_cause` 2'b00 and `rsp_cacheable` equal to the entry's cacheable flag.
- R3: A lookup whose page matches no live entry gives `rsp_trap` high with `rsp_cause` 2'b01; on every trap `rsp_paddr` is zero and `rsp_cacheable` is low.
- R4: A lookup that matches a live entry whose usable flag is clear gives `rsp_trap` high with `rsp_cause` 2'b10, for reads and for writes alike.
- R5: A write lookup (`lk_write` high) that matches a usable entry whose writable flag is clear gives `rsp_trap` high with `rsp_cause` 2'b11; a read of the same entry translates without a trap.
- R6: A software load (`wr_en` high) places the page, frame and flags in slot `wr_idx`; lookups from the next cycle on see the new entry, while a lookup in the same cycle sees the contents from before the load.
- R7: A software load also empties every other live slot holding the same page number, so at most one slot ever matches a lookup.
- R8: `flush` high empties every slot in one cycle, and takes priority over a software load in the same cycle.
- R9: After reset all slots are empty and `rsp_valid` and `rsp_trap` are low.
- R10: A cycle with no lookup request gives `rsp_valid` and `rsp_trap` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address: page number in bits 31:12, offset in bits 11:0 |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| wr_en | input | 1 | Software load of one slot |
| wr_idx | input | 3 | Slot to load |
| wr_vpn | input | 20 | Page number tag to load |
| wr_pfn | input | 20 | Frame number to load |
| wr_usable | input | 1 | Usable flag of the loaded entry |
| wr_writable | input | 1 | Writable flag of the loaded entry |
| wr_cacheable | input | 1 | Cacheable flag of the loaded entry |
| flush | input | 1 | Empty all slots |
| rsp_valid | output | 1 | Registered answer to the previous cycle's lookup |
| rsp_paddr | output | 32 | Physical address (zero on a trap) |
| rsp_cacheable | output | 1 | Cacheable flag of the hit entry (low on a trap) |
| rsp_trap | output | 1 | Trap request |
| rsp_cause | output | 2 | 00 none, 01 miss, 10 unusable entry, 11 write to read-only |

## Verification
The bench goes after the cause priority: a write to an unusable entry must report 2'b10, so a design that checked the writable flag first would report 2'b11 there. It reloads a page already held in another slot and then retags that slot, so a design that skipped the duplicate clear would still translate through the stale slot instead of missing. It issues a lookup in the same cycle as a load of the looked-up page, where a design that forwarded the write would hit instead of miss, and it raises flush together with a load, where a design that let the load win would leave one live entry behind.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer.
// Assumes a two-bit trap cause; widths of tags and frames are module parameters.
package xlat_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_MISS    = 2'b01,
        CAUSE_INVALID = 2'b10,
        CAUSE_RDONLY  = 2'b11
    } cause_e;

    // Rights flags carried by every slot.
    typedef struct packed {
        logic usable;
        logic writable;
        logic cacheable;
    } rights_t;

endpackage

// File: rtl/xlat_bank.sv
// Slot storage for the translation buffer.
// Holds tag, frame and rights per slot plus a live bit. A load writes one slot
// and kills other live slots carrying the same tag; flush kills all slots and
// wins over a load. Assumes wr_idx < ENTRIES.
module xlat_bank
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  rights_t          wr_rights,
    input  logic             flush,
    output logic [VPN_W-1:0] slot_vpn    [ENTRIES],
    output logic [PFN_W-1:0] slot_pfn    [ENTRIES],
    output rights_t          slot_rights [ENTRIES],
    output logic             slot_live   [ENTRIES]
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        logic dup;

        // Decode whether this slot is the load target or a duplicate of it.
        always_comb begin
            sel = wr_en && (wr_idx == IDX_W'(i));
            dup = wr_en && !sel && slot_live[i] && (slot_vpn[i] == wr_vpn);
        end

        // Live bit: cleared by reset, flush or duplicate, set by a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_live[i] <= 1'b0;
            end else if (flush) begin
                slot_live[i] <= 1'b0;
            end else if (sel) begin
                slot_live[i] <= 1'b1;
            end else if (dup) begin
                slot_live[i] <= 1'b0;
            end
        end

        // Payload: tag, frame and rights captured on a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vpn[i]    <= '0;
                slot_pfn[i]    <= '0;
                slot_rights[i] <= '0;
            end else if (sel && !flush) begin
                slot_vpn[i]    <= wr_vpn;
                slot_pfn[i]    <= wr_pfn;
                slot_rights[i] <= wr_rights;
            end
        end
    end

endmodule

// File: rtl/xlat_match.sv
// Associative compare and one-hot select.
// Compares the page number with every live slot and ORs together the frame and
// rights of the matching slot. Assumes at most one slot matches.
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] slot_vpn    [ENTRIES],
    input  logic [PFN_W-1:0] slot_pfn    [ENTRIES],
    input  rights_t          slot_rights [ENTRIES],
    input  logic             slot_live   [ENTRIES],
    output logic [ENTRIES-1:0] hit_vec,
    output logic             any_hit,
    output logic [PFN_W-1:0] hit_pfn,
    output rights_t          hit_rights
);

    // Per-slot tag compare gated by the live bit.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = slot_live[i] && (slot_vpn[i] == vpn);
    end

    // AND-OR select of the single matching slot.
    always_comb begin
        hit_pfn    = '0;
        hit_rights = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_pfn    = hit_pfn    | ({PFN_W{hit_vec[i]}} & slot_pfn[i]);
            hit_rights = hit_rights | ({3{hit_vec[i]}} & slot_rights[i]);
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/xlat_fault.sv
// Rights check, cause encoding and response register.
// Priority: miss, then unusable entry, then write to read-only. A trap zeroes
// the address and the cacheable flag. Responses are registered one cycle.
module xlat_fault
    import xlat_pkg::*;
#(
    parameter int PFN_W = 20,
    parameter int OFS_W = 12,
    localparam int PA_W = PFN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [OFS_W-1:0] lk_ofs,
    input  logic             any_hit,
    input  logic [PFN_W-1:0] hit_pfn,
    input  rights_t          hit_rights,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_trap,
    output cause_e           rsp_cause
);

    cause_e          cause_d;
    logic [PA_W-1:0] paddr_d;
    logic            cach_d;

    // Classify the access and form the translated address.
    always_comb begin
        if (!any_hit) begin
            cause_d = CAUSE_MISS;
        end else if (!hit_rights.usable) begin
            cause_d = CAUSE_INVALID;
        end else if (lk_write && !hit_rights.writable) begin
            cause_d = CAUSE_RDONLY;
        end else begin
            cause_d = CAUSE_NONE;
        end
        if (cause_d == CAUSE_NONE) begin
            paddr_d = {hit_pfn, lk_ofs};
            cach_d  = hit_rights.cacheable;
        end else begin
            paddr_d = '0;
            cach_d  = 1'b0;
        end
    end

    // Response register; idle cycles produce an empty response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_trap      <= 1'b0;
            rsp_cause     <= CAUSE_NONE;
        end else if (lk_valid) begin
            rsp_valid     <= 1'b1;
            rsp_paddr     <= paddr_d;
            rsp_cacheable <= cach_d;
            rsp_trap      <= (cause_d != CAUSE_NONE);
            rsp_cause     <= cause_d;
        end else begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_trap      <= 1'b0;
            rsp_cause     <= CAUSE_NONE;
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
// Fully associative translation buffer refilled by software.
// Splits the virtual address into page and offset, looks the page up in all
// slots at once and returns a registered translation or a trap request with a
// cause. Assumes software keeps wr_idx within range.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFS_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFS_W,
    localparam int PA_W   = PFN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_usable,
    input  logic             wr_writable,
    input  logic             wr_cacheable,
    input  logic             flush,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_trap,
    output logic [1:0]       rsp_cause
);

    logic [VPN_W-1:0]   slot_vpn    [ENTRIES];
    logic [PFN_W-1:0]   slot_pfn    [ENTRIES];
    rights_t            slot_rights [ENTRIES];
    logic               slot_live   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic [PFN_W-1:0]   hit_pfn;
    rights_t            hit_rights;
    rights_t            wr_rights;
    cause_e             cause_q;

    // Pack the software rights flags.
    always_comb begin
        wr_rights.usable    = wr_usable;
        wr_rights.writable  = wr_writable;
        wr_rights.cacheable = wr_cacheable;
    end

    xlat_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_vpn     (wr_vpn),
        .wr_pfn     (wr_pfn),
        .wr_rights  (wr_rights),
        .flush      (flush),
        .slot_vpn   (slot_vpn),
        .slot_pfn   (slot_pfn),
        .slot_rights(slot_rights),
        .slot_live  (slot_live)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_match (
        .vpn        (lk_vaddr[VA_W-1:OFS_W]),
        .slot_vpn   (slot_vpn),
        .slot_pfn   (slot_pfn),
        .slot_rights(slot_rights),
        .slot_live  (slot_live),
        .hit_vec    (hit_vec),
        .any_hit    (any_hit),
        .hit_pfn    (hit_pfn),
        .hit_rights (hit_rights)
    );

    xlat_fault #(.PFN_W(PFN_W), .OFS_W(OFS_W)) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_write     (lk_write),
        .lk_ofs       (lk_vaddr[OFS_W-1:0]),
        .any_hit      (any_hit),
        .hit_pfn      (hit_pfn),
        .hit_rights   (hit_rights),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_cacheable(rsp_cacheable),
        .rsp_trap     (rsp_trap),
        .rsp_cause    (cause_q)
    );

    assign rsp_cause = cause_q;

endmodule

// File: rtl/xlat_buffer_chk.sv
// Property checker for the translation buffer, bound to the top module.
module xlat_buffer_chk #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20,
    parameter int OFS_W   = 12,
    localparam int PA_W   = PFN_W + OFS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OFS_W-1:0]   lk_ofs,
    input logic               lk_write,
    input logic               flush,
    input logic               rsp_valid,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_cacheable,
    input logic               rsp_trap,
    input logic [1:0]         rsp_cause,
    input logic [ENTRIES-1:0] hit_vec
);

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !flush) |=> (rsp_trap || rsp_paddr[OFS_W-1:0] == $past(lk_ofs)));

    assert_trap_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_paddr == '0 && !rsp_cacheable && rsp_cause != 2'b00));

    assert_rdonly_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_write) |=> (rsp_cause != 2'b11));

    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (hit_vec == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_trap));

endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_ofs       (lk_vaddr[OFS_W-1:0]),
    .lk_write     (lk_write),
    .flush        (flush),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_cacheable(rsp_cacheable),
    .rsp_trap     (rsp_trap),
    .rsp_cause    (rsp_cause),
    .hit_vec      (hit_vec)
);

// File: tb/xlat_buffer_tb.sv
// Self-checking bench for the translation buffer.
module xlat_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_usable = 1'b0;
    logic        wr_writable = 1'b0;
    logic        wr_cacheable = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable;
    logic        rsp_trap;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xlat_buffer dut_i (.*);

    // {vaddr, write, cause, paddr, cacheable}
    localparam int NV = 8;
    localparam logic [67:0] VEC [NV] = '{
        {32'h0001_0123, 1'b0, 2'b00, 32'hABCD_E123, 1'b1},
        {32'h0001_0FFF, 1'b1, 2'b00, 32'hABCD_EFFF, 1'b1},
        {32'h0002_0456, 1'b0, 2'b00, 32'h1234_5456, 1'b0},
        {32'h0002_0456, 1'b1, 2'b11, 32'h0000_0000, 1'b0},
        {32'h0003_0000, 1'b0, 2'b10, 32'h0000_0000, 1'b0},
        {32'h0003_0000, 1'b1, 2'b10, 32'h0000_0000, 1'b0},
        {32'h0004_0000, 1'b0, 2'b01, 32'h0000_0000, 1'b0},
        {32'hFFFF_FABC, 1'b1, 2'b00, 32'h0000_1ABC, 1'b1}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [19:0] vpn,
                        input logic [19:0] pfn, input logic u, input logic w,
                        input logic c);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pfn = pfn;
        wr_usable = u; wr_writable = w; wr_cacheable = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a lookup at one negedge, sample the registered answer at the next.
    task automatic lookup(input logic [31:0] va, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_rsp(string req, logic [1:0] cause, logic [31:0] pa, logic c);
        check(req, {63'd0, rsp_valid}, 64'd1);
        check(req, {62'd0, rsp_cause}, {62'd0, cause});
        check(req, {63'd0, rsp_trap}, {63'd0, (cause != 2'b00)});
        check(req, {32'd0, rsp_paddr}, {32'd0, pa});
        check(req, {63'd0, rsp_cacheable}, {63'd0, c});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R9 rsp_trap", {63'd0, rsp_trap}, 64'd0);
        lookup(32'h0001_0000, 1'b0);
        expect_rsp("R9 empty after reset", 2'b01, 32'h0, 1'b0);

        // R6: software loads
        load(3'd0, 20'h00010, 20'hABCDE, 1'b1, 1'b1, 1'b1);
        load(3'd1, 20'h00020, 20'h12345, 1'b1, 1'b0, 1'b0);
        load(3'd2, 20'h00030, 20'h55555, 1'b0, 1'b1, 1'b1);
        load(3'd7, 20'hFFFFF, 20'h00001, 1'b1, 1'b1, 1'b1);

        // Vector walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            lookup(VEC[k][67:36], VEC[k][35]);
            expect_rsp($sformatf("R1/R2/R3/R4/R5 vec%0d", k),
                       VEC[k][34:33], VEC[k][32:1], VEC[k][0]);
        end

        // R10: idle cycle gives empty response
        @(negedge clk);
        check("R10 idle valid", {63'd0, rsp_valid}, 64'd0);
        check("R10 idle trap", {63'd0, rsp_trap}, 64'd0);

        // R7: reload page 0x00010 into slot 3, then retag slot 3
        load(3'd3, 20'h00010, 20'h77777, 1'b1, 1'b1, 1'b0);
        lookup(32'h0001_0042, 1'b0);
        expect_rsp("R7 newest copy", 2'b00, 32'h7777_7042, 1'b0);
        load(3'd3, 20'h00099, 20'h77777, 1'b1, 1'b1, 1'b0);
        lookup(32'h0001_0042, 1'b0);
        expect_rsp("R7 stale slot cleared", 2'b01, 32'h0, 1'b0);

        // R6: lookup in the same cycle as a load sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_vpn = 20'h00060; wr_pfn = 20'h0BEEF;
        wr_usable = 1'b1; wr_writable = 1'b1; wr_cacheable = 1'b1;
        lk_valid = 1'b1; lk_vaddr = 32'h0006_0010; lk_write = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        expect_rsp("R6 same-cycle old view", 2'b01, 32'h0, 1'b0);
        lookup(32'h0006_0010, 1'b0);
        expect_rsp("R6 next-cycle new view", 2'b00, 32'h0BEE_F010, 1'b1);

        // R8: flush empties everything
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup(32'hFFFF_F000, 1'b0);
        expect_rsp("R8 flushed slot 7", 2'b01, 32'h0, 1'b0);
        lookup(32'h0006_0010, 1'b0);
        expect_rsp("R8 flushed slot 5", 2'b01, 32'h0, 1'b0);

        // R8: flush beats a same-cycle load
        @(negedge clk);
        flush = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd4; wr_vpn = 20'h00050; wr_pfn = 20'h00123;
        wr_usable = 1'b1; wr_writable = 1'b1; wr_cacheable = 1'b1;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        lookup(32'h0005_0000, 1'b0);
        expect_rsp("R8 flush wins over load", 2'b01, 32'h0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule